// File: doc/BRIEF.md
# Queue Doorbell Decoder

This block sits behind the register window of a host-driven storage controller that uses paired submission and completion queues. It receives the host's register writes and handles those at offset 0x1000 and above. Each such write becomes either a submission-queue tail update or a completion-queue head update. The doorbells of each queue pair sit side by side at a 4-byte stride, so queue n has its submission tail at 0x1000 + 8n and its completion head at 0x1004 + 8n.

Before any update, the block checks the write against a table of queues that currently exist. Writes that are misaligned, that name a queue that does not exist, or that carry a value outside the queue are dropped with no effect and no event. An accepted submission doorbell stores the new tail and issues a fetch wake-up for that queue. An accepted completion doorbell stores the new head. If that completion queue was full before the write, the block wakes the completion poster and every submission queue attached to that completion queue. If entries still remain unconsumed after the write, the block asks for the interrupt to be raised again.

Queue existence, size and attachment come from a create/delete port driven by the admin command logic. The completion poster reports its tail through a separate port. Queue id 0 is always the admin pair: submission queue 0 always drains into completion queue 0.

Top module: `db_doorbell_decoder`

## Requirements
- R1: A write to any address below 0x1000 changes no stored pointer and produces no event.
- R2: A write whose address has bits [1:0] not equal to 00 changes nothing and produces no event.
- R3: With off = addr - 0x1000, bit 2 of off selects the doorbell kind: 0 means the submission tail of queue off>>3, and 1 means the completion head of queue off>>3.
- R4: Only bits [15:0] of the write data are used as the new pointer value. The upper data bits are ignored.
- R5: A doorbell is dropped if its queue id is not below the queue count NQ, or if the addressed queue of that kind does not exist.
- R6: A doorbell is dropped if its value is greater than or equal to the size (entry count) of the addressed queue.
- R7: An accepted submission doorbell stores the tail. On the next clock edge, sq_wake pulses for exactly one cycle on that queue's bit.
- R8: An accepted completion doorbell stores the head. The queue counts as full before the write when (tail+1) wrapped at size equals the old head. In that case, on the next edge, cq_post_wake pulses on that queue's bit and sq_wake pulses on every existing submission queue attached to it.
- R9: After an accepted completion doorbell, cq_irq pulses on that queue's bit when the new head differs from the completion tail.
- R10: Creating a queue sets its pointers to 0. Deleting a queue makes later doorbells to it be dropped. Submission queue 0 is attached to completion queue 0 whatever link is given.
- R11: After reset no queue exists, every stored pointer reads 0 and all event outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| db_wr_en | input | 1 | Register write strobe |
| db_wr_addr | input | ADDR_W | Write byte address within the controller window |
| db_wr_data | input | DATA_W | Write data |
| qt_wr_en | input | 1 | Queue table update strobe |
| qt_create | input | 1 | 1 creates, 0 deletes the addressed queue |
| qt_is_cq | input | 1 | 1 selects a completion queue, 0 a submission queue |
| qt_qid | input | QID_W | Queue id to create or delete |
| qt_size | input | 16 | Entry count of a created queue |
| qt_link | input | QID_W | Completion queue a created submission queue feeds |
| cqt_wr_en | input | 1 | Completion tail update from the poster |
| cqt_qid | input | QID_W | Completion queue whose tail moves |
| cqt_val | input | 16 | New completion tail |
| rd_is_cq | input | 1 | Read select: 1 completion head, 0 submission tail |
| rd_qid | input | QID_W | Queue id to read |
| rd_ptr | output | 16 | Selected stored pointer |
| sq_wake | output | NQ | Per-submission-queue fetch wake-up pulse |
| cq_post_wake | output | NQ | Per-completion-queue poster wake-up pulse |
| cq_irq | output | NQ | Per-completion-queue interrupt recheck pulse |

## Verification
An accepted doorbell writes its pointer and its event registers on the same clock edge that samples the write. For this reason rd_ptr, which is read without a register, and every event output show the result in the cycle right after that edge, and events stay for that one cycle only. The bench drives each write at a falling edge, lets one rising edge pass, and samples a quarter period later. The same sampling point shows that a dropped write left the pointer unchanged and raised no event. The poster's tail updates and queue table changes are applied with the same one-edge latency before the doorbells that depend on them.

// File: rtl/db_pkg.sv
package db_pkg;
  localparam int DB_PTR_W = 16;
  localparam int DB_BASE  = 32'h1000;
  typedef logic [DB_PTR_W-1:0] ptr_t;

  // Next slot of a circular queue of sz entries.
  function automatic ptr_t db_next_slot(ptr_t p, ptr_t sz);
    ptr_t n;
    n = p + ptr_t'(1);
    return (n >= sz) ? '0 : n;
  endfunction

  // A completion queue is full when one more post would meet the head.
  function automatic logic db_cq_full(ptr_t tail, ptr_t head, ptr_t sz);
    return db_next_slot(tail, sz) == head;
  endfunction

  function automatic logic [31:0] db_offset(logic [31:0] addr);
    return addr - DB_BASE;
  endfunction

  function automatic logic [31:0] db_qid_of(logic [31:0] off);
    return off >> 3;
  endfunction
endpackage

// File: rtl/db_addr_decode.sv
module db_addr_decode #(
  parameter int ADDR_W = 16,
  parameter int NQ     = 64,
  localparam int QID_W = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              is_cq,
  output logic              qid_ok,
  output logic [QID_W-1:0]  qid
);
  import db_pkg::*;

  logic [31:0] addr_ext;
  logic [31:0] off;
  logic [31:0] qid_full;

  always_comb begin
    addr_ext = 32'(addr);
    off      = db_offset(addr_ext);
    qid_full = db_qid_of(off);
    hit      = (addr_ext >= DB_BASE) && (addr[1:0] == 2'b00);
    is_cq    = off[2];
    qid_ok   = qid_full < 32'(NQ);
    qid      = qid_full[QID_W-1:0];
  end
endmodule

// File: rtl/db_queue_table.sv
module db_queue_table #(
  parameter int NQ     = 64,
  localparam int QID_W = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int PW    = db_pkg::DB_PTR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   create,
  input  logic                   is_cq,
  input  logic [QID_W-1:0]       qid,
  input  logic [PW-1:0]          size,
  input  logic [QID_W-1:0]       link,
  output logic [NQ-1:0]          sq_exists,
  output logic [NQ-1:0]          cq_exists,
  output logic [NQ-1:0][PW-1:0]  sq_size,
  output logic [NQ-1:0][PW-1:0]  cq_size,
  output logic [NQ-1:0][QID_W-1:0] sq_link
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_exists <= '0;
      cq_exists <= '0;
      sq_size   <= '0;
      cq_size   <= '0;
      sq_link   <= '0;
    end else if (wr_en) begin
      if (is_cq) begin
        cq_exists[qid] <= create;
        if (create) cq_size[qid] <= size;
      end else begin
        sq_exists[qid] <= create;
        if (create) begin
          sq_size[qid] <= size;
          // the admin submission queue always drains into completion queue 0
          sq_link[qid] <= (qid == '0) ? '0 : link;
        end
      end
    end
  end

  // R10: admin pair link stays fixed
  a_r10_admin_link: assert property (@(posedge clk) disable iff (!rst_n)
    sq_exists[0] |-> sq_link[0] == '0);
endmodule

// File: rtl/db_ptr_store.sv
module db_ptr_store #(
  parameter int NQ     = 64,
  localparam int QID_W = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int PW    = db_pkg::DB_PTR_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_en,
  input  logic                  cfg_is_cq,
  input  logic [QID_W-1:0]      cfg_qid,
  input  logic                  sq_upd,
  input  logic                  cq_upd,
  input  logic [QID_W-1:0]      upd_qid,
  input  logic [PW-1:0]         upd_val,
  input  logic                  tail_en,
  input  logic [QID_W-1:0]      tail_qid,
  input  logic [PW-1:0]         tail_val,
  input  logic [NQ-1:0]         sq_exists,
  input  logic [NQ-1:0]         cq_exists,
  input  logic [NQ-1:0][PW-1:0] sq_size,
  input  logic [NQ-1:0][PW-1:0] cq_size,
  output logic [NQ-1:0][PW-1:0] sq_tail,
  output logic [NQ-1:0][PW-1:0] cq_head,
  output logic [NQ-1:0][PW-1:0] cq_tail
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_tail <= '0;
      cq_head <= '0;
      cq_tail <= '0;
    end else begin
      if (sq_upd) sq_tail[upd_qid] <= upd_val;
      if (cq_upd) cq_head[upd_qid] <= upd_val;
      if (tail_en) cq_tail[tail_qid] <= tail_val;
      // a queue table change restarts the pointers of that queue
      if (cfg_en) begin
        if (cfg_is_cq) begin
          cq_head[cfg_qid] <= '0;
          cq_tail[cfg_qid] <= '0;
        end else begin
          sq_tail[cfg_qid] <= '0;
        end
      end
    end
  end

  for (genvar g = 0; g < NQ; g++) begin : g_bound
    // R6: stored doorbell pointers never leave their queue
    a_r6_sq_tail_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_exists[g] && sq_size[g] != '0) |-> sq_tail[g] < sq_size[g]);
    a_r6_cq_head_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (cq_exists[g] && cq_size[g] != '0) |-> cq_head[g] < cq_size[g]);
  end
endmodule

// File: rtl/db_doorbell_decoder.sv
module db_doorbell_decoder #(
  parameter int NQ     = 64,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int QID_W = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int PW    = db_pkg::DB_PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              db_wr_en,
  input  logic [ADDR_W-1:0] db_wr_addr,
  input  logic [DATA_W-1:0] db_wr_data,
  input  logic              qt_wr_en,
  input  logic              qt_create,
  input  logic              qt_is_cq,
  input  logic [QID_W-1:0]  qt_qid,
  input  logic [PW-1:0]     qt_size,
  input  logic [QID_W-1:0]  qt_link,
  input  logic              cqt_wr_en,
  input  logic [QID_W-1:0]  cqt_qid,
  input  logic [PW-1:0]     cqt_val,
  input  logic              rd_is_cq,
  input  logic [QID_W-1:0]  rd_qid,
  output logic [PW-1:0]     rd_ptr,
  output logic [NQ-1:0]     sq_wake,
  output logic [NQ-1:0]     cq_post_wake,
  output logic [NQ-1:0]     cq_irq
);
  import db_pkg::*;

  logic             dec_hit, dec_is_cq, dec_qid_ok;
  logic [QID_W-1:0] dec_qid;

  logic [NQ-1:0]          sq_exists, cq_exists;
  logic [NQ-1:0][PW-1:0]  sq_size, cq_size;
  logic [NQ-1:0][QID_W-1:0] sq_link;
  logic [NQ-1:0][PW-1:0]  sq_tail, cq_head, cq_tail;

  db_addr_decode #(.ADDR_W(ADDR_W), .NQ(NQ)) u_dec (
    .addr(db_wr_addr), .hit(dec_hit), .is_cq(dec_is_cq),
    .qid_ok(dec_qid_ok), .qid(dec_qid)
  );

  db_queue_table #(.NQ(NQ)) u_tab (
    .clk(clk), .rst_n(rst_n), .wr_en(qt_wr_en), .create(qt_create),
    .is_cq(qt_is_cq), .qid(qt_qid), .size(qt_size), .link(qt_link),
    .sq_exists(sq_exists), .cq_exists(cq_exists),
    .sq_size(sq_size), .cq_size(cq_size), .sq_link(sq_link)
  );

  // named internal events
  ptr_t new_val;
  logic q_exists;
  ptr_t q_size;
  logic db_accept;
  logic sq_accept;
  logic cq_accept;
  logic cq_was_full;
  logic cq_relieve;
  logic cq_irq_due;
  logic [NQ-1:0] sq_wake_nx, cq_post_nx, cq_irq_nx;

  always_comb begin
    new_val   = db_wr_data[PW-1:0];
    q_exists  = dec_is_cq ? cq_exists[dec_qid] : sq_exists[dec_qid];
    q_size    = dec_is_cq ? cq_size[dec_qid] : sq_size[dec_qid];
    // a queue table change in the same cycle takes precedence
    db_accept = db_wr_en && dec_hit && dec_qid_ok && q_exists &&
                (new_val < q_size) && !qt_wr_en;
    sq_accept = db_accept && !dec_is_cq;
    cq_accept = db_accept && dec_is_cq;
    cq_was_full = db_cq_full(cq_tail[dec_qid], cq_head[dec_qid], cq_size[dec_qid]);
    cq_relieve  = cq_accept && cq_was_full;
    cq_irq_due  = cq_accept && (new_val != cq_tail[dec_qid]);

    sq_wake_nx = '0;
    cq_post_nx = '0;
    cq_irq_nx  = '0;
    if (sq_accept) sq_wake_nx[dec_qid] = 1'b1;
    if (cq_relieve) begin
      cq_post_nx[dec_qid] = 1'b1;
      for (int i = 0; i < NQ; i++) begin
        if (sq_exists[i] && sq_link[i] == dec_qid) sq_wake_nx[i] = 1'b1;
      end
    end
    if (cq_irq_due) cq_irq_nx[dec_qid] = 1'b1;
  end

  db_ptr_store #(.NQ(NQ)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .cfg_en(qt_wr_en), .cfg_is_cq(qt_is_cq), .cfg_qid(qt_qid),
    .sq_upd(sq_accept), .cq_upd(cq_accept), .upd_qid(dec_qid), .upd_val(new_val),
    .tail_en(cqt_wr_en), .tail_qid(cqt_qid), .tail_val(cqt_val),
    .sq_exists(sq_exists), .cq_exists(cq_exists),
    .sq_size(sq_size), .cq_size(cq_size),
    .sq_tail(sq_tail), .cq_head(cq_head), .cq_tail(cq_tail)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_wake      <= '0;
      cq_post_wake <= '0;
      cq_irq       <= '0;
    end else begin
      sq_wake      <= sq_wake_nx;
      cq_post_wake <= cq_post_nx;
      cq_irq       <= cq_irq_nx;
    end
  end

  assign rd_ptr = rd_is_cq ? cq_head[rd_qid] : sq_tail[rd_qid];

  // R1: the control register range never raises doorbell events
  a_r1_low_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (db_wr_en && 32'(db_wr_addr) < DB_BASE) |=>
      (sq_wake == '0 && cq_post_wake == '0 && cq_irq == '0));
  // R2: misaligned writes are silent
  a_r2_misaligned_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (db_wr_en && db_wr_addr[1:0] != 2'b00) |=>
      (sq_wake == '0 && cq_post_wake == '0 && cq_irq == '0));
  // R8: only one completion queue can be relieved per write
  a_r8_post_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cq_post_wake));
  // R8: a poster wake-up follows a doorbell write
  a_r8_post_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cq_post_wake != '0) |-> $past(db_wr_en));
  // R9: at most one interrupt recheck per write
  a_r9_irq_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cq_irq));
  // R7: any wake-up follows a doorbell write
  a_r7_wake_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_wake != '0) |-> $past(db_wr_en));
endmodule

// File: tb/sim_db_doorbell_decoder.sv
module sim_db_doorbell_decoder;
  localparam int NQ = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic db_wr_en = 1'b0;
  logic [15:0] db_wr_addr = '0;
  logic [31:0] db_wr_data = '0;
  logic qt_wr_en = 1'b0, qt_create = 1'b0, qt_is_cq = 1'b0;
  logic [5:0] qt_qid = '0, qt_link = '0;
  logic [15:0] qt_size = '0;
  logic cqt_wr_en = 1'b0;
  logic [5:0] cqt_qid = '0;
  logic [15:0] cqt_val = '0;
  logic rd_is_cq = 1'b0;
  logic [5:0] rd_qid = '0;
  logic [15:0] rd_ptr;
  logic [NQ-1:0] sq_wake, cq_post_wake, cq_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  db_doorbell_decoder #(.NQ(NQ)) u0 (
    .clk(clk), .rst_n(rst_n),
    .db_wr_en(db_wr_en), .db_wr_addr(db_wr_addr), .db_wr_data(db_wr_data),
    .qt_wr_en(qt_wr_en), .qt_create(qt_create), .qt_is_cq(qt_is_cq),
    .qt_qid(qt_qid), .qt_size(qt_size), .qt_link(qt_link),
    .cqt_wr_en(cqt_wr_en), .cqt_qid(cqt_qid), .cqt_val(cqt_val),
    .rd_is_cq(rd_is_cq), .rd_qid(rd_qid), .rd_ptr(rd_ptr),
    .sq_wake(sq_wake), .cq_post_wake(cq_post_wake), .cq_irq(cq_irq)
  );

  typedef struct packed {
    logic [15:0] addr;
    logic [31:0] data;
    logic        rcq;
    logic [5:0]  rq;
    logic [15:0] eptr;
    logic [63:0] esq;
    logic [63:0] ecq;
    logic [63:0] eirq;
    logic [7:0]  req;
  } vec_t;

  // Queues: CQ0 size4 tail2, SQ0 size8, CQ1 size4 tail3 (full), SQ1->CQ1 size16, SQ2->CQ1 size8
  localparam vec_t VECS [12] = '{
    '{16'h1000, 32'd5,          1'b0, 6'd0, 16'd5, 64'h1, 64'h0, 64'h0, 8'd7},  // R7, R3
    '{16'h1008, 32'hABCD0007,   1'b0, 6'd1, 16'd7, 64'h2, 64'h0, 64'h0, 8'd4},  // R4
    '{16'h0FF8, 32'd3,          1'b0, 6'd0, 16'd5, 64'h0, 64'h0, 64'h0, 8'd1},  // R1
    '{16'h1002, 32'd1,          1'b0, 6'd0, 16'd5, 64'h0, 64'h0, 64'h0, 8'd2},  // R2
    '{16'h1010, 32'd8,          1'b0, 6'd2, 16'd0, 64'h0, 64'h0, 64'h0, 8'd6},  // R6
    '{16'h1018, 32'd1,          1'b0, 6'd3, 16'd0, 64'h0, 64'h0, 64'h0, 8'd5},  // R5 missing
    '{16'h1200, 32'd0,          1'b0, 6'd0, 16'd5, 64'h0, 64'h0, 64'h0, 8'd5},  // R5 id 64
    '{16'h1010, 32'd7,          1'b0, 6'd2, 16'd7, 64'h4, 64'h0, 64'h0, 8'd7},  // R7
    '{16'h100C, 32'd1,          1'b1, 6'd1, 16'd1, 64'h6, 64'h2, 64'h2, 8'd8},  // R8, R9
    '{16'h100C, 32'd3,          1'b1, 6'd1, 16'd3, 64'h0, 64'h0, 64'h0, 8'd9},  // R9 head==tail
    '{16'h1004, 32'd1,          1'b1, 6'd0, 16'd1, 64'h0, 64'h0, 64'h1, 8'd3},  // R3 cq, R9
    '{16'h100C, 32'd4,          1'b1, 6'd1, 16'd3, 64'h0, 64'h0, 64'h0, 8'd6}   // R6 cq
  };

  task automatic check(string what, int req, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic qt(bit create, bit is_cq, int qid, int size, int link);
    @(negedge clk);
    qt_wr_en = 1'b1; qt_create = create; qt_is_cq = is_cq;
    qt_qid = 6'(qid); qt_size = 16'(size); qt_link = 6'(link);
    @(negedge clk);
    qt_wr_en = 1'b0;
  endtask

  task automatic cqt(int qid, int val);
    @(negedge clk);
    cqt_wr_en = 1'b1; cqt_qid = 6'(qid); cqt_val = 16'(val);
    @(negedge clk);
    cqt_wr_en = 1'b0;
  endtask

  // drive a doorbell, wait one rising edge, sample a quarter period later
  task automatic ring(logic [15:0] a, logic [31:0] d, bit rcq, int rq);
    @(negedge clk);
    db_wr_en = 1'b1; db_wr_addr = a; db_wr_data = d;
    rd_is_cq = rcq; rd_qid = 6'(rq);
    @(posedge clk);
    #5;
  endtask

  task automatic events(int req, logic [63:0] esq, logic [63:0] ecq, logic [63:0] eirq);
    check("sq_wake", req, 64'(sq_wake), esq);
    check("cq_post_wake", req, 64'(cq_post_wake), ecq);
    check("cq_irq", req, 64'(cq_irq), eirq);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R11: reset state
    check("reset rd_ptr", 11, 64'(rd_ptr), 64'h0);
    events(11, 64'h0, 64'h0, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    // R11: no queue exists after reset, doorbell dropped
    ring(16'h1000, 32'd1, 1'b0, 0);
    check("rd after reset ring", 11, 64'(rd_ptr), 64'h0);
    events(11, 64'h0, 64'h0, 64'h0);
    @(negedge clk); db_wr_en = 1'b0;

    qt(1'b1, 1'b1, 0, 4, 0);
    qt(1'b1, 1'b0, 0, 8, 1);   // link given 1, forced to 0 (R10)
    qt(1'b1, 1'b1, 1, 4, 0);
    qt(1'b1, 1'b0, 1, 16, 1);
    qt(1'b1, 1'b0, 2, 8, 1);
    cqt(0, 2);
    cqt(1, 3);

    for (int k = 0; k < 12; k++) begin
      ring(VECS[k].addr, VECS[k].data, VECS[k].rcq, int'(VECS[k].rq));
      check($sformatf("vec%0d rd_ptr", k), int'(VECS[k].req), 64'(rd_ptr), 64'(VECS[k].eptr));
      events(int'(VECS[k].req), VECS[k].esq, VECS[k].ecq, VECS[k].eirq);
      @(negedge clk); db_wr_en = 1'b0;
      // pulses last a single cycle (R7)
      @(posedge clk); #5;
      check("pulse ends", 7, 64'(sq_wake | cq_post_wake | cq_irq), 64'h0);
    end

    // R10: SQ0 feeds CQ0 despite link 1; CQ0 full (tail0, head1) relieved
    cqt(0, 0);
    ring(16'h1004, 32'd0, 1'b1, 0);
    check("admin relief head", 10, 64'(rd_ptr), 64'h0);
    events(10, 64'h1, 64'h1, 64'h0);
    @(negedge clk); db_wr_en = 1'b0;

    // R10: deleted queue drops doorbells, recreated queue restarts at 0
    qt(1'b0, 1'b0, 1, 0, 0);
    ring(16'h1008, 32'd2, 1'b0, 1);
    events(10, 64'h0, 64'h0, 64'h0);
    @(negedge clk); db_wr_en = 1'b0;
    qt(1'b1, 1'b0, 1, 16, 1);
    @(posedge clk); #5;
    check("recreated sq1 tail", 10, 64'(rd_ptr), 64'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule